// File: doc/BRIEF.md
# Multi-Converter Result Packer for DMA

This block sits between two or three analog-to-digital converters that sample in lockstep and a DMA channel. Each time the converters finish together, a single strobe delivers one 12-bit result per converter. The block places these results into 32-bit transfer words and presents each word with a request/acknowledge handshake. A 2-bit packing mode sets the word layout. One choice sends each result alone in the low half-word. Another places two results per word, one in each 16-bit half. A third places two results per word as bytes in the low 16 bits.

The results form a stream in the order first converter, second converter, then third converter (the third only when the triple selector is set). In the paired layouts, each two consecutive stream entries make up one word, with the later entry in the upper position. In triple operation this gives a rotating order across conversions: (second, first), then (first, third), then (third, second). A result left unpaired at the end of one conversion is kept and paired with the first result of the next conversion. The transfer count can be limited: when the continuous bit is clear, requests stop after a programmed number of accepted words. A sticky flag reports results that were dropped because the previous word had not been taken.

Top module: `adc_dma_packer`

## Requirements
- R1: With `mode` = 2'b00, `dma_req` stays low and conversion strobes are ignored. No word is produced later because of them.
- R2: With `mode` = 2'b01, each word holds one result in bits [11:0], with bits [31:12] zero. In triple operation the words follow the order first, second, third converter for every conversion.
- R3: With `mode` = 2'b10 and triple set, results from successive conversions form the word sequence {second,first}, {first,third}, {third,second}, repeating. The earlier-named result sits in bits [27:16] and the later-named result in bits [11:0]. All other bits are zero.
- R4: With `mode` = 2'b11, the word uses the same pair order as R3. The upper-position result's low 8 bits go in bits [15:8], the lower-position result's low 8 bits go in bits [7:0], and bits [31:16] are zero.
- R5: With triple clear, modes 2'b10 and 2'b11 produce exactly one word per conversion holding {second,first}. Mode 2'b01 produces first, then second.
- R6: With `continuous` = 0, no request is raised after `xfer_limit` words have been accepted, and later conversions produce nothing. With `continuous` = 1, words keep flowing regardless of the count.
- R7: A strobe that arrives while a complete word is waiting, with no acknowledge in that cycle, sets `overrun`. The results of that strobe are dropped. `overrun` then stays set until reset.
- R8: Clearing `enable`, or changing `mode` or `triple`, discards buffered results, returns the pair rotation to its start and clears the transfer count. No request appears in the cycle after.
- R9: After a synchronous reset, `dma_req`, `overrun` and `dma_data` are all zero until the first full word is formed.
- R10: While `dma_req` is high and `dma_ack` is low, `dma_data` holds its value and the request stays up. The exception is a restart condition (R8) or a change to the count controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low clears position and count |
| mode | input | 2 | Packing mode: 00 off, 01 single half-word, 10 half-word pairs, 11 byte pairs |
| triple | input | 1 | 1: three converters, 0: two converters |
| continuous | input | 1 | 1: no transfer limit; 0: stop after `xfer_limit` words |
| xfer_limit | input | CNT_W | Number of words allowed when not continuous |
| conv_done | input | 1 | One-cycle strobe: all results valid together |
| res_a | input | RES_W | First converter result |
| res_b | input | RES_W | Second converter result |
| res_c | input | RES_W | Third converter result |
| dma_ack | input | 1 | Word accepted in this cycle when `dma_req` is high |
| dma_data | output | 32 | Packed transfer word, zero when no request |
| dma_req | output | 1 | A word is waiting for acceptance |
| overrun | output | 1 | Sticky: a conversion was dropped |

## Verification
Each layout is driven in triple and in dual operation with distinct values on every converter, so that a swapped half or a wrong rotation step gives a mismatch. Two back-to-back triple conversions in the paired layouts show whether the left-over third result is carried over to the next word. Result values with nonzero upper nibbles separate the byte layout from the half-word layout. A stalled acknowledge with a second strobe checks that the new results are dropped. Separate runs with a limited count and with a mode change check that the stop point is respected and that the rotation restarts.

// File: rtl/adcpack_pkg.sv
package adcpack_pkg;

  localparam int NUM_CH = 3;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    PM_OFF    = 2'b00,
    PM_HALF   = 2'b01,
    PM_PAIR16 = 2'b10,
    PM_PAIR8  = 2'b11
  } pack_mode_e;

  // Number of stream entries consumed by one transfer word.
  function automatic logic [1:0] group_size(pack_mode_e m);
    return (m == PM_HALF) ? 2'd1 : 2'd2;
  endfunction

  // Form the transfer word from the earlier (lo) and later (hi) entries.
  function automatic logic [WORD_W-1:0] pack_word(pack_mode_e m,
                                                  logic [15:0] lo,
                                                  logic [15:0] hi);
    logic [WORD_W-1:0] w;
    case (m)
      PM_HALF:   w = {16'h0000, lo};
      PM_PAIR16: w = {hi, lo};
      PM_PAIR8:  w = {16'h0000, hi[7:0], lo[7:0]};
      default:   w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/adcpack_stream.sv
module adcpack_stream #(
  parameter int RES_W  = 12,
  parameter int NUM_CH = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         push,
  input  logic                         triple,
  input  logic                         pop,
  input  logic [1:0]                   grp,
  input  logic [NUM_CH-1:0][RES_W-1:0] res,
  output logic [RES_W-1:0]             elem_lo,
  output logic [RES_W-1:0]             elem_hi,
  output logic                         word_ready,
  output logic                         blocked
);

  localparam int DEPTH = NUM_CH + 1;
  localparam int FW    = $clog2(DEPTH + 1);

  logic [RES_W-1:0] slots [DEPTH];
  logic [RES_W-1:0] nxt   [DEPTH];
  logic [FW-1:0]    fill, nfill, remain, n_push;

  assign n_push     = triple ? FW'(NUM_CH) : FW'(NUM_CH - 1);
  assign word_ready = fill >= FW'(grp);
  assign remain     = pop ? (fill - FW'(grp)) : fill;
  assign blocked    = remain >= FW'(grp);
  assign elem_lo    = slots[0];
  assign elem_hi    = slots[1];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop) nxt[i] = (i + int'(grp) < DEPTH) ? slots[i + int'(grp)] : '0;
      else     nxt[i] = slots[i];
    end
    nfill = remain;
    if (push) begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (k < int'(n_push) && int'(remain) + k < DEPTH)
          nxt[int'(remain) + k] = res[k];
      end
      nfill = remain + n_push;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      fill <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= nxt[i];
      fill <= nfill;
    end
  end

endmodule

// File: rtl/adcpack_xfer.sv
module adcpack_xfer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             hs,
  input  logic             continuous,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  assign done = !continuous && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear)                cnt <= '0;
    else if (hs && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/adcpack_ctrl.sv
module adcpack_ctrl
  import adcpack_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  pack_mode_e mode,
  input  logic       triple,
  input  logic       conv_done,
  input  logic       blocked,
  input  logic       done,
  output logic       restart,
  output logic       active,
  output logic       accept,
  output logic       ovr_event,
  output logic       overrun
);

  pack_mode_e mode_q;
  logic       triple_q;

  assign restart   = !enable || (mode != mode_q) || (triple != triple_q);
  assign active    = enable && (mode != PM_OFF) && !restart && !done;
  assign ovr_event = conv_done && active && blocked;
  assign accept    = conv_done && active && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PM_OFF;
      triple_q <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      mode_q   <= mode;
      triple_q <= triple;
      if (ovr_event) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_dma_packer.sv
module adc_dma_packer
  import adcpack_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              triple,
  input  logic              continuous,
  input  logic [CNT_W-1:0]  xfer_limit,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  res_a,
  input  logic [RES_W-1:0]  res_b,
  input  logic [RES_W-1:0]  res_c,
  input  logic              dma_ack,
  output logic [WORD_W-1:0] dma_data,
  output logic              dma_req,
  output logic              overrun
);

  pack_mode_e                 mode_e;
  logic [1:0]                 grp;
  logic [NUM_CH-1:0][RES_W-1:0] res_vec;
  logic [RES_W-1:0]           elem_lo, elem_hi;
  logic                       word_ready, blocked, done;
  logic                       restart, active, accept, ovr_event, hs;

  assign mode_e  = pack_mode_e'(mode);
  assign grp     = group_size(mode_e);
  assign res_vec = {res_c, res_b, res_a};
  assign dma_req = active && word_ready;
  assign hs      = dma_req && dma_ack;

  adcpack_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .mode      (mode_e),
    .triple    (triple),
    .conv_done (conv_done),
    .blocked   (blocked),
    .done      (done),
    .restart   (restart),
    .active    (active),
    .accept    (accept),
    .ovr_event (ovr_event),
    .overrun   (overrun)
  );

  adcpack_stream #(.RES_W(RES_W), .NUM_CH(NUM_CH)) u_stream (
    .clk        (clk),
    .rst        (rst),
    .clear      (restart),
    .push       (accept),
    .triple     (triple),
    .pop        (hs),
    .grp        (grp),
    .res        (res_vec),
    .elem_lo    (elem_lo),
    .elem_hi    (elem_hi),
    .word_ready (word_ready),
    .blocked    (blocked)
  );

  adcpack_xfer #(.CNT_W(CNT_W)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .clear      (restart),
    .hs         (hs),
    .continuous (continuous),
    .limit      (xfer_limit),
    .done       (done)
  );

  assign dma_data = dma_req ? pack_word(mode_e, 16'(elem_lo), 16'(elem_hi)) : '0;

endmodule

// File: rtl/adcpack_chk.sv
module adcpack_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             continuous,
  input logic [CNT_W-1:0] xfer_limit,
  input logic             conv_done,
  input logic             dma_ack,
  input logic [31:0]      dma_data,
  input logic             dma_req,
  input logic             overrun,
  input logic             restart
);

  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |-> !dma_req); // R1

  AST_HALF_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dma_req && mode == 2'b01) |-> dma_data[31:12] == 20'h0); // R2

  AST_PAIR16_GAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dma_req && mode == 2'b10) |-> (dma_data[31:28] == 4'h0 && dma_data[15:12] == 4'h0)); // R3

  AST_BYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dma_req && mode == 2'b11) |-> dma_data[31:16] == 16'h0); // R4

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R7

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(conv_done)); // R7

  AST_RESTART_FLUSH: assert property (@(posedge clk) disable iff (rst)
    restart |=> !dma_req); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dma_req && !overrun && dma_data == 32'h0)); // R9

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_ack) |=> (restart || !$stable(continuous) || !$stable(xfer_limit)
                               || (dma_req && $stable(dma_data)))); // R10

endmodule

bind adc_dma_packer adcpack_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .continuous (continuous),
  .xfer_limit (xfer_limit),
  .conv_done  (conv_done),
  .dma_ack    (dma_ack),
  .dma_data   (dma_data),
  .dma_req    (dma_req),
  .overrun    (overrun),
  .restart    (restart)
);

// File: tb/sim_adc_dma_packer.sv
`timescale 1ns/1ps
module sim_adc_dma_packer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        triple = 1'b1;
  logic        continuous = 1'b1;
  logic [15:0] xfer_limit = '0;
  logic        conv_done = 1'b0;
  logic [11:0] res_a = '0, res_b = '0, res_c = '0;
  logic        dma_ack = 1'b1;
  logic [31:0] dma_data;
  logic        dma_req;
  logic        overrun;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] expq[$];
  string       tagq[$];

  always #4 clk = ~clk;

  adc_dma_packer u0 (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .triple(triple),
    .continuous(continuous), .xfer_limit(xfer_limit), .conv_done(conv_done),
    .res_a(res_a), .res_b(res_b), .res_c(res_c), .dma_ack(dma_ack),
    .dma_data(dma_data), .dma_req(dma_req), .overrun(overrun)
  );

  function automatic logic [31:0] w_half(logic [11:0] v);
    return {20'h0, v};
  endfunction
  function automatic logic [31:0] w_p16(logic [11:0] up, logic [11:0] dn);
    return {4'h0, up, 4'h0, dn};
  endfunction
  function automatic logic [31:0] w_p8(logic [11:0] up, logic [11:0] dn);
    return {16'h0, up[7:0], dn[7:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_word(input logic [31:0] w, input string tag);
    expq.push_back(w);
    tagq.push_back(tag);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic convert(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c, input int idle);
    @(posedge clk); #2;
    conv_done = 1'b1; res_a = a; res_b = b; res_c = c;
    @(posedge clk); #2;
    conv_done = 1'b0;
    cycles(idle);
  endtask

  task automatic setup(input logic en, input logic [1:0] m, input logic tr);
    @(posedge clk); #2;
    enable = en; mode = m; triple = tr;
    cycles(2);
  endtask

  // Monitor: compare every accepted word with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && dma_req && dma_ack) begin
      if (expq.size() == 0) begin
        check(1'b0, "unexpected word (R1/R6/R7)", dma_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(dma_data === e, t, dma_data, e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] held;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    check(dma_req == 1'b0 && overrun == 1'b0, "R9 reset outputs", {30'h0, dma_req, overrun}, 32'h0);
    check(dma_data == 32'h0, "R9 reset data", dma_data, 32'h0);

    // R1: mode off ignores strobes
    setup(1'b1, 2'b00, 1'b1);
    convert(12'h111, 12'h222, 12'h333, 2);
    @(negedge clk);
    check(dma_req == 1'b0, "R1 no request when off", {31'h0, dma_req}, 32'h0);
    setup(1'b1, 2'b01, 1'b1);
    @(negedge clk);
    check(dma_req == 1'b0, "R1 strobe while off left nothing", {31'h0, dma_req}, 32'h0);

    // R2: single half-words, triple order
    expect_word(w_half(12'hA01), "R2 first");
    expect_word(w_half(12'hB02), "R2 second");
    expect_word(w_half(12'hC03), "R2 third");
    convert(12'hA01, 12'hB02, 12'hC03, 5);
    expect_word(w_half(12'h5A5), "R2 first again");
    expect_word(w_half(12'h6B6), "R2 second again");
    expect_word(w_half(12'h7C7), "R2 third again");
    convert(12'h5A5, 12'h6B6, 12'h7C7, 5);

    // R3: half-word pairs, rotation across conversions
    setup(1'b1, 2'b10, 1'b1);
    expect_word(w_p16(12'h112, 12'h111), "R3 pair second/first");
    convert(12'h111, 12'h112, 12'h113, 4);
    expect_word(w_p16(12'h221, 12'h113), "R3 pair first/third carried");
    expect_word(w_p16(12'h223, 12'h222), "R3 pair third/second");
    convert(12'h221, 12'h222, 12'h223, 5);

    // R4: byte pairs, same rotation, low bytes only
    setup(1'b1, 2'b11, 1'b1);
    expect_word(w_p8(12'hF2B, 12'hE1A), "R4 byte pair second/first");
    convert(12'hE1A, 12'hF2B, 12'hD3C, 4);
    expect_word(w_p8(12'h94D, 12'hD3C), "R4 byte pair first/third carried");
    expect_word(w_p8(12'hB6F, 12'hA5E), "R4 byte pair third/second");
    convert(12'h94D, 12'hA5E, 12'hB6F, 5);

    // R5: dual operation
    setup(1'b1, 2'b10, 1'b0);
    expect_word(w_p16(12'h3B3, 12'h3A3), "R5 dual pair");
    convert(12'h3A3, 12'h3B3, 12'h3C3, 4);
    expect_word(w_p16(12'h4B4, 12'h4A4), "R5 dual pair again");
    convert(12'h4A4, 12'h4B4, 12'h4C4, 4);
    setup(1'b1, 2'b11, 1'b0);
    expect_word(w_p8(12'h7D2, 12'h8E1), "R5 dual byte pair");
    convert(12'h8E1, 12'h7D2, 12'h6F3, 4);
    setup(1'b1, 2'b01, 1'b0);
    expect_word(w_half(12'h0A1), "R5 dual half first");
    expect_word(w_half(12'h0B2), "R5 dual half second");
    convert(12'h0A1, 12'h0B2, 12'h0C3, 4);

    // R8: mode change drops carried entry and restarts rotation
    setup(1'b1, 2'b10, 1'b1);
    expect_word(w_p16(12'h612, 12'h611), "R8 before change");
    convert(12'h611, 12'h612, 12'h613, 4);
    setup(1'b1, 2'b11, 1'b1);
    @(negedge clk);
    check(dma_req == 1'b0, "R8 carried entry flushed", {31'h0, dma_req}, 32'h0);
    expect_word(w_p8(12'h722, 12'h721), "R8 rotation restarted");
    convert(12'h721, 12'h722, 12'h723, 4);

    // R6: transfer limit
    @(posedge clk); #2;
    continuous = 1'b0; xfer_limit = 16'd4;
    setup(1'b0, 2'b01, 1'b1);
    setup(1'b1, 2'b01, 1'b1);
    expect_word(w_half(12'h801), "R6 limited 1");
    expect_word(w_half(12'h802), "R6 limited 2");
    expect_word(w_half(12'h803), "R6 limited 3");
    convert(12'h801, 12'h802, 12'h803, 5);
    expect_word(w_half(12'h901), "R6 limited 4");
    convert(12'h901, 12'h902, 12'h903, 5);
    @(negedge clk);
    check(dma_req == 1'b0, "R6 stopped at limit", {31'h0, dma_req}, 32'h0);
    convert(12'hA11, 12'hA12, 12'hA13, 5);
    @(negedge clk);
    check(dma_req == 1'b0, "R6 strobe after limit ignored", {31'h0, dma_req}, 32'h0);
    // R8: enable toggle clears the count
    setup(1'b0, 2'b01, 1'b1);
    setup(1'b1, 2'b01, 1'b1);
    expect_word(w_half(12'hB01), "R8 count cleared 1");
    expect_word(w_half(12'hB02), "R8 count cleared 2");
    expect_word(w_half(12'hB03), "R8 count cleared 3");
    convert(12'hB01, 12'hB02, 12'hB03, 5);
    @(posedge clk); #2;
    continuous = 1'b1; xfer_limit = 16'd0;
    expect_word(w_half(12'hC01), "R6 continuous 1");
    expect_word(w_half(12'hC02), "R6 continuous 2");
    expect_word(w_half(12'hC03), "R6 continuous 3");
    convert(12'hC01, 12'hC02, 12'hC03, 5);

    // R7 / R10: stalled acceptance and overrun
    @(posedge clk); #2;
    dma_ack = 1'b0;
    check(overrun == 1'b0, "R7 no overrun yet", {31'h0, overrun}, 32'h0);
    convert(12'hD01, 12'hD02, 12'hD03, 2);
    @(negedge clk);
    held = dma_data;
    check(dma_req == 1'b1 && held == w_half(12'hD01), "R10 word waiting", held, w_half(12'hD01));
    @(negedge clk);
    check(dma_data == held && dma_req == 1'b1, "R10 word held", dma_data, held);
    convert(12'hE01, 12'hE02, 12'hE03, 1);
    @(negedge clk);
    check(overrun == 1'b1, "R7 overrun set", {31'h0, overrun}, 32'h1);
    expect_word(w_half(12'hD01), "R7 kept 1");
    expect_word(w_half(12'hD02), "R7 kept 2");
    expect_word(w_half(12'hD03), "R7 kept 3");
    @(posedge clk); #2;
    dma_ack = 1'b1;
    cycles(8);
    @(negedge clk);
    check(overrun == 1'b1, "R7 overrun sticky", {31'h0, overrun}, 32'h1);
    check(dma_req == 1'b0, "R7 dropped data absent", {31'h0, dma_req}, 32'h0);

    cycles(2);
    check(expq.size() == 0, "scoreboard drained", expq.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule